// File: doc/BRIEF.md
# Weighted Pseudorandom Pattern Generator

This block is a stimulus source for built-in self-test. A shift register of configurable length steps through a pseudorandom sequence defined by a characteristic-polynomial parameter. At run time, a mode input chooses how the feedback is formed. In the external form, the parity of the tapped stages is shifted into the first stage. In the internal form, the last stage is fed back into XOR gates placed between neighbouring stages. Both forms use the same polynomial, so both run through every nonzero state when that polynomial is primitive.

Next to the raw register bits, the block drives a vector of weighted bits. Each weighted bit has its own 2-bit code, which sets how likely that bit is to be 1. The bit is built from a small group of register stages joined by an AND gate, an OR gate, or a plain wire. A seed can be loaded at any time. An all-zero seed is replaced by a safe start state, so the register can never lock up.

Top module: `wprpg`

## Requirements
- R1: While `rst_n` is low, the state is the single-1 value, with only bit W-1 set (0x80 for W=8).
- R2: When `load` is high at a clock edge, the state takes `seed` on that edge, whatever `en` is.
- R3: A load with `seed` equal to zero gives the single-1 value (bit W-1 set) instead of zero.
- R4: When `load` and `en` are both low, the state keeps its value.
- R5: With `mode`=0 and `en`=1 (no load), the next state is {state[W-2:0], p}, where p is the XOR of state[i] over every i with POLY[i]=1. POLY bit i is the coefficient of x^(i+1).
- R6: With `mode`=1 and `en`=1 (no load), the next state[0] is state[W-1]. For i ≥ 1, the next state[i] is state[i-1] XOR (POLY[i-1] AND state[W-1]).
- R7: With the default primitive polynomial, the state returns to its seed after exactly 2^W-1 steps in either mode, and not earlier.
- R8: Over one full period, bit W-1 of the state is 1 in exactly 2^(W-1) of the states, one more than the number of 0s.
- R9: Weighted bit j uses the state bits a=(3j)%W, b=(3j+1)%W and c=(3j+2)%W. Its code is the 2-bit field wsel[2j+1:2j]. Code 00 gives a (weight 1/2). Code 01 gives a|b (weight 3/4). Code 10 gives a|b|c (weight 7/8). Code 11 gives a&b&c (weight 1/8).
- R10: Over one full period with W=8, the number of 1s is 128 for code 00, 192 for code 01, 224 for code 10 and 32 for code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the register one step |
| load | input | 1 | Load the seed; takes priority over `en` |
| mode | input | 1 | 0 = external-XOR feedback, 1 = internal-XOR feedback |
| seed | input | W | Start value; zero is replaced by the single-1 value |
| wsel | input | 2*NW | 2-bit weight code for each weighted bit |
| state_q | output | W | Register state |
| wout | output | NW | Weighted output bits |

## Verification
The bench uses the default build: W=8, four weighted bits, and the primitive polynomial x^8+x^6+x^5+x^4+1 (POLY=0xB8). At this size a full period is only 255 steps. That lets the bench walk the whole period in both feedback forms and count the exact number of 1s for every weight code. It can also show that the state returns to its seed on step 255 and on no earlier step.

// File: rtl/wprpg.sv
module wprpg #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'hB8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          mode,
  input  logic [W-1:0]  seed,
  input  logic [2*NW-1:0] wsel,
  output logic [W-1:0]  state_q,
  output logic [NW-1:0] wout
);
  localparam logic [W-1:0] SINGLE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] st, ext_nx, int_nx, seed_ok;

  assign ext_nx    = {st[W-2:0], ^(st & POLY)};
  assign int_nx[0] = st[W-1];

  for (genvar i = 1; i < W; i++) begin : g_int
    assign int_nx[i] = st[i-1] ^ (POLY[i-1] & st[W-1]);
  end

  assign seed_ok = (seed == '0) ? SINGLE : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= SINGLE;
    else if (load) st <= seed_ok;
    else if (en)   st <= mode ? int_nx : ext_nx;
  end

  assign state_q = st;

  for (genvar j = 0; j < NW; j++) begin : g_w
    localparam int PA = (3*j) % W;
    localparam int PB = (3*j+1) % W;
    localparam int PC = (3*j+2) % W;
    logic [1:0] code;
    assign code = wsel[2*j +: 2];
    assign wout[j] = (code == 2'b00) ? st[PA] :
                     (code == 2'b01) ? (st[PA] | st[PB]) :
                     (code == 2'b10) ? (st[PA] | st[PB] | st[PC]) :
                                       (st[PA] & st[PB] & st[PC]);
  end
endmodule

module wprpg_chk #(
  parameter int W = 8,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          load,
  input logic          mode,
  input logic [W-1:0]  seed,
  input logic [2*NW-1:0] wsel,
  input logic [W-1:0]  state_q,
  input logic [NW-1:0] wout
);
  localparam logic [W-1:0] SINGLE = {1'b1, {(W-1){1'b0}}};

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> state_q == SINGLE); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load && seed != '0 |=> state_q == $past(seed)); // R2
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    load && seed == '0 |=> state_q == SINGLE); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !en |=> $stable(state_q)); // R4
  AST_EXT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load && !mode |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R5
  AST_INT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load && mode |=> state_q[0] == $past(state_q[W-1])); // R6
  AST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0); // R7
endmodule

bind wprpg wprpg_chk #(.W(W), .NW(NW)) u_chk (.*);

// File: tb/wprpg_tb.sv
module wprpg_tb;
  localparam int W = 8;
  localparam int NW = 4;
  localparam logic [W-1:0] POLY = 8'hB8;

  logic clk = 0, rst_n = 0, en = 0, load = 0, mode = 0;
  logic [W-1:0] seed = '0;
  logic [2*NW-1:0] wsel = '0;
  logic [W-1:0] state_q;
  logic [NW-1:0] wout;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  wprpg #(.W(W), .POLY(POLY), .NW(NW)) u_dut (.*);

  // {mode, seed, wsel}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b0, 8'h01, 8'hE4}, {1'b0, 8'hA5, 8'h1B}, {1'b0, 8'hFF, 8'h55},
    {1'b1, 8'h01, 8'hE4}, {1'b1, 8'h3C, 8'hAA}, {1'b1, 8'h80, 8'hFF}
  };

  function automatic logic [W-1:0] nxt(input logic m, input logic [W-1:0] s);
    logic [W-1:0] r;
    logic p;
    if (!m) begin
      p = 1'b0;
      for (int i = 0; i < W; i++) if (POLY[i]) p = p ^ s[i];
      r = {s[W-2:0], p};
    end else begin
      r[0] = s[W-1];
      for (int i = 1; i < W; i++) r[i] = s[i-1] ^ (POLY[i-1] & s[W-1]);
    end
    return r;
  endfunction

  function automatic logic [NW-1:0] wmod(input logic [W-1:0] s, input logic [2*NW-1:0] c);
    logic [NW-1:0] r;
    for (int j = 0; j < NW; j++) begin
      logic a, b, d;
      a = s[(3*j)%W]; b = s[(3*j+1)%W]; d = s[(3*j+2)%W];
      case (c[2*j +: 2])
        2'b00: r[j] = a;
        2'b01: r[j] = a | b;
        2'b10: r[j] = a | b | d;
        default: r[j] = a & b & d;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic period_run(input logic m);
    int n;
    int c0, c1, c2, c3, top;
    logic [W-1:0] s0;
    mode = m; wsel = 8'hE4; seed = 8'h01; load = 1; en = 1;
    cyc(); load = 0; s0 = state_q;
    n = 0; c0 = 0; c1 = 0; c2 = 0; c3 = 0; top = 0;
    for (int k = 0; k < 300; k++) begin
      c0 += wout[0]; c1 += wout[1]; c2 += wout[2]; c3 += wout[3]; top += state_q[W-1];
      cyc(); n++;
      if (state_q == s0) break;
    end
    chk(n == 255, "R7 period", n, 255);
    chk(top == 128, "R8 ones count", top, 128);
    chk(c0 == 128, "R10 weight 1/2", c0, 128);
    chk(c1 == 192, "R10 weight 3/4", c1, 192);
    chk(c2 == 224, "R10 weight 7/8", c2, 224);
    chk(c3 == 32,  "R10 weight 1/8", c3, 32);
    en = 0;
  endtask

  initial begin
    #(8*150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] exp;
    wsel = 8'hE4;
    repeat (3) cyc();
    chk(state_q == 8'h80, "R1 reset state", state_q, 8'h80);
    chk(wout == wmod(8'h80, 8'hE4), "R9 weights at reset", wout, wmod(8'h80, 8'hE4));
    rst_n = 1;
    cyc();
    chk(state_q == 8'h80, "R4 hold after reset", state_q, 8'h80);

    foreach (VEC[v]) begin
      mode = VEC[v][16]; seed = VEC[v][15:8]; wsel = VEC[v][7:0];
      load = 1; en = 0;
      cyc();
      load = 0; en = 1;
      chk(state_q == seed, "R2 load", state_q, seed);
      exp = seed;
      for (int k = 0; k < 16; k++) begin
        cyc();
        exp = nxt(mode, exp);
        if (!mode) chk(state_q == exp, "R5 external step", state_q, exp);
        else       chk(state_q == exp, "R6 internal step", state_q, exp);
        chk(wout == wmod(exp, wsel), "R9 weighted bits", wout, wmod(exp, wsel));
      end
      en = 0;
    end

    seed = 8'h5A; load = 1; cyc(); load = 0; en = 0;
    repeat (3) cyc();
    chk(state_q == 8'h5A, "R4 hold with en low", state_q, 8'h5A);

    en = 1; seed = 8'h33; load = 1; cyc();
    chk(state_q == 8'h33, "R2 load beats enable", state_q, 8'h33);

    mode = 0; seed = 8'h00; load = 1; cyc();
    chk(state_q == 8'h80, "R3 zero seed mode 0", state_q, 8'h80);
    mode = 1; load = 1; seed = 8'h00; cyc();
    chk(state_q == 8'h80, "R3 zero seed mode 1", state_q, 8'h80);
    load = 0; en = 0;

    period_run(1'b0);
    period_run(1'b1);

    rst_n = 0; #1;
    chk(state_q == 8'h80, "R1 async reset", state_q, 8'h80);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule